// File: doc/BRIEF.md
# Peripheral Bus Access Timeout Monitor

This block sits between one bus master and a group of peripheral registers, on a simple valid/ready request channel with a separate response channel. It passes each request through to the peripheral side. It then counts the clock cycles until the peripheral answers. If no answer comes within a programmable number of cycles, the monitor ends the transfer itself with an error response to the master. It also raises a sticky interrupt and captures the address of the stalled access together with a 7-bit identity of the master that issued it.

One transfer is in flight at a time. Software reaches the block through a small register port with three entries:

| Index | Register | Contents |
|-------|----------|----------|
| 0 | Configuration | Threshold, clear bit and protection enable |
| 1 | Address capture | Read-only |
| 2 | Identity capture | Read-only |

Reads return data one cycle after the index is presented. When protection is switched off, the monitor never times out and waits for the peripheral for as long as it takes.

Top module: `periph_timeout_mon`

## Requirements
- R1: After reset:
  - the threshold is 65535, protection is enabled and the interrupt is low;
  - both capture registers read 0.
  - The configuration word is laid out as bits 15:0 = threshold, bit 16 = interrupt clear, bit 17 = protection enable.
- R2: Request pass-through and blocking:
  - While no transfer is open, `p_req_valid` follows `m_req_valid`, the request fields pass through unchanged, and `m_req_ready` follows `p_req_ready`.
  - Once a request is accepted, `m_req_ready` stays low until that transfer ends.
- R3: Normal response. Counting from the cycle after acceptance as waiting cycle 1, a peripheral response in waiting cycle k, with k <= max(threshold,1), is forwarded to the master one cycle later, carrying its read data and error flag.
- R4: Timeout. With protection enabled, if no response arrives through waiting cycle max(threshold,1):
  - the master receives a response with the error flag set and read data 0, one cycle later;
  - the interrupt rises on the same clock edge.
- R5: A peripheral response that arrives while no transfer is open, including a late answer to a timed-out transfer, is discarded and produces no master response.
- R6: With protection disabled (bit 17 = 0), no timeout occurs. The transfer waits for the peripheral response and the interrupt stays low.
- R7: A timeout captures the 32-bit access address, and the identity as {permission[1:0], master ID[4:0]`}`. The master ID sits in bits 4:0 and the permission in bits 6:5.
- R8: While the interrupt is pending, further timeouts leave both capture registers unchanged.
- R9: Clearing:
  - Writing a configuration word with bit 16 = 1 clears the interrupt and zeroes the identity capture, while the address capture is kept.
  - Bit 16 = 0 has no effect on the interrupt.
  - Bit 16 always reads back 0.
- R10: If a clear write and a timeout fall in the same cycle, the timeout wins. The interrupt stays high and the new address and identity are captured.
- R11: Register port:
  - Reads return the entry selected by `reg_idx` one cycle later.
  - Writes to indices 1 and 2 are ignored.
  - Index 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the monitored bus |
| rst | input | 1 | Synchronous active-high reset |
| m_req_valid | input | 1 | Master request valid |
| m_req_ready | output | 1 | Request accepted by peripheral side |
| m_req_addr | input | ADDR_W | Request address |
| m_req_write | input | 1 | Request is a write |
| m_req_wdata | input | DATA_W | Write data |
| m_req_mid | input | MID_W | Issuing master ID |
| m_req_perm | input | PERM_W | Issuing master permission level |
| m_rsp_valid | output | 1 | Response to master (one-cycle pulse) |
| m_rsp_err | output | 1 | Response carries an error |
| m_rsp_rdata | output | DATA_W | Response read data |
| p_req_valid | output | 1 | Request valid toward peripheral |
| p_req_ready | input | 1 | Peripheral accepts the request |
| p_req_addr | output | ADDR_W | Address toward peripheral |
| p_req_write | output | 1 | Write flag toward peripheral |
| p_req_wdata | output | DATA_W | Write data toward peripheral |
| p_rsp_valid | input | 1 | Peripheral response pulse |
| p_rsp_err | input | 1 | Peripheral response error |
| p_rsp_rdata | input | DATA_W | Peripheral read data |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 2 | Register index (0 config, 1 address, 2 identity) |
| reg_wdata | input | THR_W+2 | Register write data |
| reg_rdata | output | RD_W | Registered read data |
| irq | output | 1 | Sticky timeout interrupt |

## Verification
Some internal faults show at the response channel within a single transfer:
- A counter that is off by one moves the master response by one cycle.
- A counter that is off by one also flips error and normal completion at the k = threshold and k = threshold+1 boundary.

The sweep over every threshold from 0 to 5 and every response delay from 1 to 7 lands on both sides of that boundary.

A wait state that never closes shows up on the next request: `m_req_ready` stays low. The sweep's following transfer catches it within a few cycles.

Capture and clear faults are seen only through the register port and `irq`. These are checked by readback right after each timeout and after each clear, including the pending, simultaneous-clear and late-response orderings.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [0:0] {ST_IDLE = 1'b0, ST_WAIT = 1'b1} xfer_state_e;

  localparam int REG_IDX_W = 2;
  localparam logic [REG_IDX_W-1:0] IDX_CFG  = 2'd0;
  localparam logic [REG_IDX_W-1:0] IDX_ADDR = 2'd1;
  localparam logic [REG_IDX_W-1:0] IDX_UID  = 2'd2;
endpackage

// File: rtl/ptm_wait_counter.sv
// Counts waiting cycles of the open transfer and flags expiry.
module ptm_wait_counter #(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             active,
  input  logic             rsp_seen,
  input  logic             prot_en,
  input  logic [THR_W-1:0] thr,
  output logic             expire
);
  localparam int CNT_W = THR_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_next;

  always_comb begin
    cnt_next = {1'b0, cnt} + 1'b1;
    expire   = active && !rsp_seen && prot_en &&
               (cnt_next >= {2'b00, thr});
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt <= '0;
    end else if (active && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

  // A new transfer always begins with an empty count.
  p_cnt_restart_r3: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt == '0));
endmodule

// File: rtl/ptm_capture.sv
// Sticky interrupt plus address and identity capture.
module ptm_capture #(
  parameter int ADDR_W = 32,
  parameter int UID_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [UID_W-1:0]  uid_in,
  output logic              irq,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [UID_W-1:0]  cap_uid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      cap_addr <= '0;
      cap_uid  <= '0;
    end else if (fire) begin
      irq <= 1'b1;
      if (!irq || clr) begin
        cap_addr <= addr_in;
        cap_uid  <= uid_in;
      end
    end else if (clr) begin
      irq     <= 1'b0;
      cap_uid <= '0;
    end
  end

  p_first_kept_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr) |=> ($stable(cap_addr) && $stable(cap_uid)));

  p_clear_zeroes_uid_r9: assert property (@(posedge clk) disable iff (rst)
    (clr && !fire) |=> (!irq && cap_uid == '0 && $stable(cap_addr)));

  p_timeout_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && fire) |=> (irq && cap_addr == $past(addr_in) && cap_uid == $past(uid_in)));
endmodule

// File: rtl/ptm_regs.sv
// Configuration register, clear pulse and registered read mux.
module ptm_regs
  import ptm_pkg::*;
#(
  parameter int THR_W  = 16,
  parameter int ADDR_W = 32,
  parameter int UID_W  = 7,
  parameter int RD_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [THR_W+1:0]     reg_wdata,
  input  logic [ADDR_W-1:0]    cap_addr,
  input  logic [UID_W-1:0]     cap_uid,
  output logic [THR_W-1:0]     thr,
  output logic                 prot_en,
  output logic                 clr_pulse,
  output logic [RD_W-1:0]      reg_rdata
);
  localparam int CLR_BIT  = THR_W;
  localparam int PROT_BIT = THR_W + 1;

  logic cfg_wr;

  always_comb begin
    cfg_wr    = reg_wr && (reg_idx == IDX_CFG);
    clr_pulse = cfg_wr && reg_wdata[CLR_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      thr     <= {THR_W{1'b1}};
      prot_en <= 1'b1;
    end else if (cfg_wr) begin
      thr     <= reg_wdata[THR_W-1:0];
      prot_en <= reg_wdata[PROT_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_idx)
        IDX_CFG:  reg_rdata <= RD_W'({prot_en, 1'b0, thr});
        IDX_ADDR: reg_rdata <= RD_W'(cap_addr);
        IDX_UID:  reg_rdata <= RD_W'(cap_uid);
        default:  reg_rdata <= '0;
      endcase
    end
  end

  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> ($stable(thr) && $stable(prot_en)));
endmodule

// File: rtl/periph_timeout_mon.sv
module periph_timeout_mon
  import ptm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int MID_W  = 5,
  parameter int PERM_W = 2,
  parameter int THR_W  = 16,
  parameter int RD_W   = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 m_req_valid,
  output logic                 m_req_ready,
  input  logic [ADDR_W-1:0]    m_req_addr,
  input  logic                 m_req_write,
  input  logic [DATA_W-1:0]    m_req_wdata,
  input  logic [MID_W-1:0]     m_req_mid,
  input  logic [PERM_W-1:0]    m_req_perm,
  output logic                 m_rsp_valid,
  output logic                 m_rsp_err,
  output logic [DATA_W-1:0]    m_rsp_rdata,
  output logic                 p_req_valid,
  input  logic                 p_req_ready,
  output logic [ADDR_W-1:0]    p_req_addr,
  output logic                 p_req_write,
  output logic [DATA_W-1:0]    p_req_wdata,
  input  logic                 p_rsp_valid,
  input  logic                 p_rsp_err,
  input  logic [DATA_W-1:0]    p_rsp_rdata,
  input  logic                 reg_wr,
  input  logic [REG_IDX_W-1:0] reg_idx,
  input  logic [THR_W+1:0]     reg_wdata,
  output logic [RD_W-1:0]      reg_rdata,
  output logic                 irq
);
  localparam int UID_W = MID_W + PERM_W;

  xfer_state_e       state;
  logic              idle, accept, rsp_take, fire;
  logic [ADDR_W-1:0] hold_addr;
  logic [UID_W-1:0]  hold_uid;
  logic [THR_W-1:0]  thr;
  logic              prot_en, clr_pulse;
  logic [ADDR_W-1:0] cap_addr;
  logic [UID_W-1:0]  cap_uid;

  always_comb begin
    idle        = (state == ST_IDLE);
    p_req_valid = idle && m_req_valid;
    p_req_addr  = m_req_addr;
    p_req_write = m_req_write;
    p_req_wdata = m_req_wdata;
    m_req_ready = idle && p_req_ready;
    accept      = idle && m_req_valid && p_req_ready;
    rsp_take    = !idle && p_rsp_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hold_addr <= '0;
      hold_uid  <= '0;
    end else if (accept) begin
      state     <= ST_WAIT;
      hold_addr <= m_req_addr;
      hold_uid  <= {m_req_perm, m_req_mid};
    end else if (rsp_take || fire) begin
      state <= ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rsp_valid <= 1'b0;
      m_rsp_err   <= 1'b0;
      m_rsp_rdata <= '0;
    end else begin
      m_rsp_valid <= rsp_take || fire;
      m_rsp_err   <= fire || (rsp_take && p_rsp_err);
      m_rsp_rdata <= rsp_take ? p_rsp_rdata : '0;
    end
  end

  ptm_wait_counter #(.THR_W(THR_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .active   (!idle),
    .rsp_seen (p_rsp_valid),
    .prot_en  (prot_en),
    .thr      (thr),
    .expire   (fire)
  );

  ptm_capture #(.ADDR_W(ADDR_W), .UID_W(UID_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .fire     (fire),
    .clr      (clr_pulse),
    .addr_in  (hold_addr),
    .uid_in   (hold_uid),
    .irq      (irq),
    .cap_addr (cap_addr),
    .cap_uid  (cap_uid)
  );

  ptm_regs #(.THR_W(THR_W), .ADDR_W(ADDR_W), .UID_W(UID_W), .RD_W(RD_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_idx   (reg_idx),
    .reg_wdata (reg_wdata),
    .cap_addr  (cap_addr),
    .cap_uid   (cap_uid),
    .thr       (thr),
    .prot_en   (prot_en),
    .clr_pulse (clr_pulse),
    .reg_rdata (reg_rdata)
  );

  p_accept_blocks_r2: assert property (@(posedge clk) disable iff (rst)
    (m_req_valid && m_req_ready) |=> !m_req_ready);

  p_single_rsp_r3: assert property (@(posedge clk) disable iff (rst)
    m_rsp_valid |=> !m_rsp_valid);

  p_irq_with_err_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> (m_rsp_valid && m_rsp_err));

  p_late_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    (idle && p_rsp_valid) |=> !m_rsp_valid);

  p_unprot_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !prot_en |=> !$rose(irq));
endmodule

// File: tb/periph_timeout_mon_bench.sv
module periph_timeout_mon_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_req_valid = 1'b0, m_req_write = 1'b0;
  logic [31:0] m_req_addr = '0, m_req_wdata = '0;
  logic [4:0]  m_req_mid = '0;
  logic [1:0]  m_req_perm = '0;
  logic        m_req_ready, m_rsp_valid, m_rsp_err;
  logic [31:0] m_rsp_rdata;
  logic        p_req_valid, p_req_write;
  logic [31:0] p_req_addr, p_req_wdata;
  logic        p_req_ready = 1'b0, p_rsp_valid = 1'b0, p_rsp_err = 1'b0;
  logic [31:0] p_rsp_rdata = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_idx = '0;
  logic [17:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  periph_timeout_mon u_periph_timeout_mon (
    .clk(clk), .rst(rst),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready), .m_req_addr(m_req_addr),
    .m_req_write(m_req_write), .m_req_wdata(m_req_wdata), .m_req_mid(m_req_mid),
    .m_req_perm(m_req_perm), .m_rsp_valid(m_rsp_valid), .m_rsp_err(m_rsp_err),
    .m_rsp_rdata(m_rsp_rdata), .p_req_valid(p_req_valid), .p_req_ready(p_req_ready),
    .p_req_addr(p_req_addr), .p_req_write(p_req_write), .p_req_wdata(p_req_wdata),
    .p_rsp_valid(p_rsp_valid), .p_rsp_err(p_rsp_err), .p_rsp_rdata(p_rsp_rdata),
    .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [17:0] cfg(input int thr, input bit clr, input bit prot);
    return {prot, clr, 16'(thr)};
  endfunction

  task automatic wr(input logic [1:0] idx, input logic [17:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b0; reg_idx = idx;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // One transfer. d: waiting cycle of the peripheral response; e: expected
  // waiting cycle of the master response; clr_at: waiting cycle of a clear write.
  task automatic xfer(input logic [31:0] a, input logic [4:0] mid, input logic [1:0] perm,
                      input int d, input int e, input bit exp_err, input int clr_at,
                      input logic [17:0] clr_word, input logic [31:0] rdat, input string tag);
    int n_rsp = 0;
    int got_cyc = -1;
    logic got_err = 1'b0;
    logic [31:0] got_data = '0;
    int lim = ((d > e) ? d : e) + 2;
    @(negedge clk);
    m_req_valid = 1'b1; m_req_addr = a; m_req_mid = mid; m_req_perm = perm;
    m_req_write = a[2]; m_req_wdata = ~a; p_req_ready = 1'b1;
    #1;
    chk(p_req_valid && p_req_addr == a && p_req_wdata == ~a && m_req_ready,
        "R2", {tag, " pass-through"}, p_req_addr, a);
    for (int j = 1; j <= lim; j++) begin
      @(negedge clk);
      if (j >= 2 && m_rsp_valid) begin
        n_rsp++; got_cyc = j - 1; got_err = m_rsp_err; got_data = m_rsp_rdata;
      end
      if (j == 1)
        chk(!m_req_ready, "R2", {tag, " ready blocked"}, {31'b0, m_req_ready}, 32'd0);
      m_req_valid = 1'b0; p_req_ready = 1'b0;
      p_rsp_valid = (j == d); p_rsp_rdata = rdat; p_rsp_err = 1'b0;
      reg_wr = (j == clr_at); reg_idx = 2'd0; reg_wdata = clr_word;
    end
    @(negedge clk);
    p_rsp_valid = 1'b0; reg_wr = 1'b0;
    chk(n_rsp == 1, exp_err ? "R5" : "R3", {tag, " response count"}, n_rsp, 1);
    chk(got_cyc == e, exp_err ? "R4" : "R3", {tag, " response cycle"}, got_cyc, e);
    chk(got_err == exp_err && got_data == (exp_err ? 32'd0 : rdat),
        exp_err ? "R4" : "R3", {tag, " response err/data"}, got_data, exp_err ? 32'd0 : rdat);
  endtask

  initial begin
    logic [31:0] v;
    int eff, e;
    bit err;
    logic [31:0] a, a1;
    logic [4:0]  mid;
    logic [1:0]  perm;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!irq, "R1", "irq after reset", {31'b0, irq}, 0);
    rd(2'd0, v); chk(v == 32'h0002_FFFF, "R1", "config reset", v, 32'h0002_FFFF);
    rd(2'd1, v); chk(v == 0, "R1", "address capture reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1", "identity capture reset", v, 0);
    rd(2'd3, v); chk(v == 0, "R11", "index 3 reads zero", v, 0);

    // R11 writes to capture entries ignored
    wr(2'd1, 18'h3_ABCD); wr(2'd2, 18'h0_007F);
    rd(2'd1, v); chk(v == 0, "R11", "address write ignored", v, 0);
    rd(2'd2, v); chk(v == 0, "R11", "identity write ignored", v, 0);

    // Sweep threshold x response delay (R3, R4, R5, R7, R9)
    for (int thr = 0; thr <= 5; thr++) begin
      for (int d = 1; d <= 7; d++) begin
        eff = (thr == 0) ? 1 : thr;
        err = (d > eff);
        e = err ? eff : d;
        a = 32'hA000_0000 + 32'(thr * 256 + d * 4);
        mid = 5'((thr * 7 + d) & 31);
        perm = 2'(d & 3);
        wr(2'd0, cfg(thr, 1'b0, 1'b1));
        xfer(a, mid, perm, d, e, err, 0, '0, 32'h5000_0000 + 32'(d), "sweep");
        chk(irq == err, "R4", "irq after transfer", {31'b0, irq}, {31'b0, err});
        if (err) begin
          rd(2'd1, v); chk(v == a, "R7", "captured address", v, a);
          rd(2'd2, v); chk(v == {25'b0, perm, mid}, "R7", "captured identity", v, {25'b0, perm, mid});
          wr(2'd0, cfg(thr, 1'b1, 1'b1));
          #1;
          chk(!irq, "R9", "irq cleared", {31'b0, irq}, 0);
          rd(2'd2, v); chk(v == 0, "R9", "identity zero after clear", v, 0);
          rd(2'd1, v); chk(v == a, "R9", "address held after clear", v, a);
        end
      end
    end

    // R9 clear bit reads back 0
    wr(2'd0, cfg(4, 1'b1, 1'b1));
    rd(2'd0, v); chk(v == 32'h0002_0004, "R9", "clear bit reads zero", v, 32'h0002_0004);

    // R6 protection disabled
    wr(2'd0, cfg(2, 1'b0, 1'b0));
    xfer(32'hB000_0010, 5'd3, 2'd1, 10, 10, 1'b0, 0, '0, 32'h1234_5678, "unprotected");
    chk(!irq, "R6", "no irq when unprotected", {31'b0, irq}, 0);

    // R8 first event kept while pending
    wr(2'd0, cfg(2, 1'b0, 1'b1));
    a1 = 32'hC000_0100;
    xfer(a1, 5'd9, 2'd2, 9, 2, 1'b1, 0, '0, 32'h0, "first");
    xfer(32'hC000_0200, 5'd17, 2'd3, 9, 2, 1'b1, 0, '0, 32'h0, "second");
    rd(2'd1, v); chk(v == a1, "R8", "first address kept", v, a1);
    rd(2'd2, v); chk(v == {25'b0, 2'd2, 5'd9}, "R8", "first identity kept", v, {25'b0, 2'd2, 5'd9});
    // R9 writing 0 to the clear bit has no effect
    wr(2'd0, cfg(3, 1'b0, 1'b1));
    #1;
    chk(irq, "R9", "clear bit 0 leaves irq", {31'b0, irq}, 1);

    // R10 clear and timeout in the same cycle: timeout wins
    xfer(32'hD000_0300, 5'd21, 2'd1, 20, 3, 1'b1, 3, cfg(3, 1'b1, 1'b1), 32'h0, "race");
    chk(irq, "R10", "irq stays set", {31'b0, irq}, 1);
    rd(2'd1, v); chk(v == 32'hD000_0300, "R10", "new address captured", v, 32'hD000_0300);
    rd(2'd2, v); chk(v == {25'b0, 2'd1, 5'd21}, "R10", "new identity captured", v, {25'b0, 2'd1, 5'd21});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule